// File: doc/BRIEF.md
# Two-wire bus recovery sequencer

This block sits on the controller side of a two-wire serial bus. A transfer can be cut short by a reset or a protocol error. When that happens, a target device may be left holding the data line low in the middle of a byte. A single-cycle `recover_i` command starts the sequencer, which then frees the bus without help from software.

The sequencer works in three steps:

- **Clocking.** It clocks SCL while leaving SDA undriven, so the stuck target can shift out the rest of its byte. It samples SDA at the end of every SCL high phase.
- **Start and stop.** As soon as SDA reads high, it stops clocking. It then puts a start condition and a stop condition on the bus, so every target's bus logic returns to idle.
- **Failure.** If SDA is still low after the pulse limit, it releases both lines and raises a failure flag.

Both lines are open-drain. An output of 1 on an enable pulls that line low, and 0 releases it. The synchronised SDA level read back from the pad is the only input the sequencer observes. There is no data stream. All pins are plain control and status levels or pulses.

Top module: `twi_unstick`

## Requirements
- R1: While reset is asserted and right after it, `scl_oe_o`, `sda_oe_o`, `busy_o`, `done_o` and `fail_o` are all 0.
- R2: A `recover_i` pulse seen while idle sets `busy_o` and pulls SCL low from the next cycle on. A `recover_i` seen while busy has no effect on the sequence.
- R3: Every SCL low phase lasts exactly `HALF_CLKS` system clocks. Every clocking high phase also lasts exactly `HALF_CLKS` system clocks.
- R4: `sda_oe_o` stays 0 for the whole clocking phase, up to and including the high phase in which SDA is first seen high.
- R5: SDA is sampled at the end of each SCL high phase. Clocking stops after the first high phase in which SDA reads high, so the number of clock pulses equals the index of that phase.
- R6: No more than `MAX_PULSES` (9) SCL pulses are produced in the clocking phase.
- R7: On success, SDA is pulled low while SCL is still high (one start condition). SCL is then held low for one half-period and released with SDA still low. After one half-period, SDA is released while SCL is high (one stop condition). SCL therefore rises exactly once more than the clocking pulse count.
- R8: On success, `done_o` is high for exactly one cycle, in the first cycle in which `busy_o` is low again. It never pulses on failure.
- R9: If SDA is still low after the last allowed pulse, `fail_o` goes to 1 and both enables are released. No start or stop is issued. `fail_o` holds until the next accepted command clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| recover_i | input | 1 | Recovery command, taken only while idle |
| sda_in_i | input | 1 | Level of the SDA line read back from the pad |
| scl_oe_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse when a recovery has ended with start and stop |
| fail_o | output | 1 | SDA never released within the pulse limit; held until the next command |

## Verification
The SCL drive is due one clock after an accepted command. Each later line change is due a whole number of half-periods after the one before it. The SDA sample sees the pad as it was `SYNC_STAGES` clocks before the end of the high phase. `done_o` appears in the first idle cycle.

The bench samples every signal on the falling clock edge. It counts SCL and SDA transitions and measures the length of each SCL phase, instead of checking at fixed timestamps. Its final checks run only after `busy_o` has dropped and a few more cycles have passed, which covers the late `done_o` pulse. It sweeps a model target that releases SDA after 0 to 11 pulses, which exercises the success, last-pulse and failure cases.

// File: rtl/recov_pkg.sv
package recov_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_START,
    ST_HOLD,
    ST_STOPSU,
    ST_STOP
  } rec_state_e;
endpackage

// File: rtl/recov_sync.sv
module recov_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '1;
    end else begin
      pipe_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/recov_tick.sv
module recov_tick #(
  parameter int HALF = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!run_i)         cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == LAST);

  // R3
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/twi_unstick.sv
module twi_unstick
  import recov_pkg::*;
#(
  parameter int HALF_CLKS   = 4,
  parameter int MAX_PULSES  = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic recover_i,
  input  logic sda_in_i,
  output logic scl_oe_o,
  output logic sda_oe_o,
  output logic busy_o,
  output logic done_o,
  output logic fail_o
);
  localparam int PCW = $clog2(MAX_PULSES + 1);
  localparam logic [PCW-1:0] PLIM = PCW'(MAX_PULSES);

  rec_state_e     state_q, state_d;
  logic [PCW-1:0] pulses_q, pulses_d;
  logic           fail_q, fail_d, done_q, done_d;
  logic           tick, sda_seen, run;

  assign run = (state_q != ST_IDLE);

  recov_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(sda_in_i), .q_o(sda_seen)
  );

  recov_tick #(.HALF(HALF_CLKS)) u_tick (
    .clk_i (clk_i), .rst_ni(rst_ni), .run_i(run), .tick_o(tick)
  );

  always_comb begin
    state_d  = state_q;
    pulses_d = pulses_q;
    fail_d   = fail_q;
    done_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (recover_i) begin
        state_d  = ST_LOW;
        pulses_d = '0;
        fail_d   = 1'b0;
      end
      ST_LOW: if (tick) begin
        state_d  = ST_HIGH;
        pulses_d = pulses_q + 1'b1;
      end
      ST_HIGH: if (tick) begin
        if (sda_seen)              state_d = ST_START;
        else if (pulses_q == PLIM) begin
          state_d = ST_IDLE;
          fail_d  = 1'b1;
        end else                   state_d = ST_LOW;
      end
      ST_START:  if (tick) state_d = ST_HOLD;
      ST_HOLD:   if (tick) state_d = ST_STOPSU;
      ST_STOPSU: if (tick) state_d = ST_STOP;
      ST_STOP: if (tick) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      pulses_q <= '0;
      fail_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      pulses_q <= pulses_d;
      fail_q   <= fail_d;
      done_q   <= done_d;
    end
  end

  assign scl_oe_o = (state_q == ST_LOW) || (state_q == ST_HOLD);
  assign sda_oe_o = (state_q == ST_START) || (state_q == ST_HOLD) ||
                    (state_q == ST_STOPSU);
  assign busy_o   = run;
  assign done_o   = done_q;
  assign fail_o   = fail_q;

  // R6
  pulse_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulses_q <= PLIM);

  // R5
  start_after_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> ($past(sda_seen) && !scl_oe_o));

  // R3
  scl_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(scl_oe_o) |-> ($past(tick) || $past(state_q == ST_IDLE)));

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && !fail_o));

  // R9
  fail_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fail_o) |-> ($past(!sda_seen) && pulses_q == PLIM && !scl_oe_o && !sda_oe_o));
endmodule

// File: tb/twi_unstick_tb_top.sv
module twi_unstick_tb_top;
  localparam int HALF = 4;
  localparam int MAXP = 9;

  logic clk = 1'b0, rst_n = 1'b0, recover = 1'b0;
  logic scl_oe, sda_oe, busy, done, fail;
  logic scl_line, sda_line, slave_hold;
  int   falls = 0, k_cur = 0;
  int   errors = 0, checks = 0;
  int   rises, starts, stops, dones, early, badphase, runlen, exp_pulses;
  logic prev_scl = 1'b1, prev_sda = 1'b1, prev_busy = 1'b0;

  always #5 clk = ~clk;

  assign slave_hold = (falls <= k_cur);
  assign scl_line   = !scl_oe;
  assign sda_line   = !(sda_oe || slave_hold);

  twi_unstick #(.HALF_CLKS(HALF), .MAX_PULSES(MAXP), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .recover_i(recover), .sda_in_i(sda_line),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .busy_o(busy), .done_o(done), .fail_o(fail)
  );

  always @(negedge clk) begin
    if (scl_line != prev_scl) begin
      if (prev_busy && !prev_scl && runlen != HALF) badphase++;          // low runs
      if (prev_busy && prev_scl && !sda_oe && runlen != HALF) badphase++; // clocking highs
      if (scl_line) rises++;
      else falls++;
      runlen = 1;
    end else runlen++;
    if (prev_scl && scl_line && prev_sda && !sda_line) starts++;
    if (prev_scl && scl_line && !prev_sda && sda_line) stops++;
    if (sda_oe && rises < exp_pulses) early++;
    if (done) dones++;
    prev_scl  = scl_line;
    prev_sda  = sda_line;
    prev_busy = busy;
  end

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic run_case(int k, bit poke);
    bit exp_fail;
    int guard;
    exp_fail   = (k >= MAXP);
    @(posedge clk);
    falls      = 0;
    k_cur      = k;
    exp_pulses = exp_fail ? MAXP : k + 1;
    #1;
    prev_sda = sda_line; prev_scl = scl_line; prev_busy = busy;
    rises = 0; starts = 0; stops = 0; dones = 0; early = 0; badphase = 0; runlen = 0;
    @(negedge clk) recover = 1'b1;
    @(negedge clk) recover = 1'b0;
    // R2: busy and SCL drive one cycle after the command
    check(busy && scl_oe, "R2", "busy/scl_oe after command", {busy, scl_oe}, 3);
    if (poke) begin
      repeat (3 * HALF) @(negedge clk);
      recover = 1'b1;
      @(negedge clk) recover = 1'b0;
    end
    guard = 0;
    while (busy && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    check(guard < 5000, "R2", "sequence ended", guard, 0);
    repeat (3) @(negedge clk);
    // R5 R6: pulse count from SCL rising edges (plus one for the stop on success)
    check(rises == (exp_fail ? MAXP : k + 2), "R5", $sformatf("scl rises k=%0d", k),
          rises, exp_fail ? MAXP : k + 2);
    check(starts == (exp_fail ? 0 : 1), "R7", $sformatf("start conditions k=%0d", k),
          starts, exp_fail ? 0 : 1);
    check(stops == (exp_fail ? 0 : 1), "R7", $sformatf("stop conditions k=%0d", k),
          stops, exp_fail ? 0 : 1);
    check(dones == (exp_fail ? 0 : 1), "R8", $sformatf("done cycles k=%0d", k),
          dones, exp_fail ? 0 : 1);
    check(fail == exp_fail, "R9", $sformatf("fail flag k=%0d", k), fail, exp_fail);
    check(early == 0, "R4", $sformatf("sda driven while clocking k=%0d", k), early, 0);
    check(badphase == 0, "R3", $sformatf("phase length errors k=%0d", k), badphase, 0);
    check(!scl_oe && !sda_oe, "R9", "both lines released at end", {scl_oe, sda_oe}, 0);
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check(!scl_oe && !sda_oe && !busy && !done && !fail, "R1", "outputs in reset",
              {scl_oe, sda_oe, busy, done, fail}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!scl_oe && !sda_oe && !busy && !done && !fail, "R1", "outputs after reset",
              {scl_oe, sda_oe, busy, done, fail}, 0);
        for (int k = 0; k < 12; k++) run_case(k, 1'b0);
        // R9: fail holds while idle
        repeat (20) @(negedge clk);
        check(fail == 1'b1, "R9", "fail held while idle", fail, 1);
        // R2: command while busy is ignored (counts must match the plain run)
        run_case(3, 1'b1);
        run_case(MAXP - 1, 1'b1);
        run_case(MAXP, 1'b1);
        run_case(0, 1'b0);
      end
      begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule